// File: doc/BRIEF.md
# Hierarchical Locality Traffic Generator

This block is a synthetic packet source for one core of a large on-chip network. Each packet it emits is a single 256-bit flit that carries the core's own address, a chosen destination address and a sequence number. Destinations follow a nested locality model. The core address space is split into base-4 digits. Four cores form a level-1 cluster, four such clusters form a level-2 cluster, and so on up to the full 1024-core system at level 5. An 8-bit locality threshold sets how likely a packet is to escape each successive cluster. A threshold of zero keeps all traffic inside the smallest cluster. A threshold near the top of the range sends almost all traffic to the outermost level.

A 64-bit pseudo-random register, seeded at reset, supplies one escape draw per level and the bits that place the destination inside the chosen cluster. A programmable gap counter spaces packets apart, which sets the injection rate. A new flit is formed only once the previous one has been taken over the valid/ready handshake, so no packet is ever dropped.

Top module: `loc_traffic_gen`

## Requirements
- R1: While rst_n is low, flit_valid_o is 0 and the random state loads seed_i. A seed of zero is replaced by the value 1.
- R2: The flit fields are: bits [9:0] hold the source address (src_id_i captured when the flit is formed), bits [19:10] hold the destination, bits [35:20] hold the sequence number, and all higher bits are zero.
- R3: The sequence number of the first flit after reset is 0 and rises by one for each flit formed.
- R4: The level is chosen by comparing byte k of the random state (bits 8k+7..8k, k = 0..3) with alpha_i. The level is k+1 for the lowest k whose byte is not below alpha_i, and 5 if all four bytes are below it. With alpha_i = 0 the level is always 1.
- R5: With level L and address digits d = 0..4 (digit d = bits 2d+1..2d):
  - Digits above L-1 are copied from the source.
  - Digit L-1 equals (source digit + 1 + (state bits [39:32] mod 3)) mod 4.
  - Digits below L-1 are taken from state bits [47:40] at the same position.
  - As a result, the destination never equals the source.
- R6: A flit is formed from the current random state. The state then advances by 64 steps. In each step, a state whose bit 0 is 1 is shifted right and XORed with 64'hD800_0000_0000_0000, and a state whose bit 0 is 0 is only shifted right.
- R7: While flit_valid_o is 1 and flit_ready_i is 0, the flit stays valid and unchanged on the next cycle.
- R8: With enable_i held high, flit_valid_o stays low for exactly rate_i + 1 cycles after a flit is accepted. rate_i is sampled on the accepting edge.
- R9: While enable_i is low, no new flit is formed and the random state does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_i | input | 64 | Random-state seed loaded during reset |
| enable_i | input | 1 | Allows new flits to be formed |
| src_id_i | input | 10 | Address of this core |
| alpha_i | input | 8 | Per-level escape threshold |
| rate_i | input | 16 | Idle cycles added after each accepted flit |
| flit_valid_o | output | 1 | Flit available |
| flit_ready_i | input | 1 | Sink takes the flit |
| flit_data_o | output | 256 | Flit: source, destination, sequence number |

## Verification
The hardest case to reach from the ports is the outermost escape, where all four draws fall below the threshold. Its mirror image is the fully local case, where no draw may escape. The stimulus reaches both by running whole phases at a threshold of 255 and at a threshold of 0. A bench-side model of the random state predicts every destination exactly. Random backpressure and a disabled interval between bursts show that a stalled or paused source neither skips nor repeats a random state.

// File: rtl/ltg_pkg.sv
package ltg_pkg;
    localparam int unsigned STATE_W   = 64;
    localparam int unsigned DRAW_W    = 8;
    localparam int unsigned DIGIT_W   = 2;
    localparam logic [STATE_W-1:0] FB_MASK    = 64'hD800_0000_0000_0000;
    localparam logic [STATE_W-1:0] ZERO_SEED  = 64'h0000_0000_0000_0001;
endpackage

// File: rtl/ltg_lfsr.sv
module ltg_lfsr
    import ltg_pkg::*;
#(
    parameter int unsigned STEPS = 64,
    parameter int unsigned OUT_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] seed_i,
    input  logic               adv_i,
    output logic [OUT_W-1:0]   state_o
);
    logic [STATE_W-1:0] state_q, state_d, walk;

    always_comb begin
        walk = state_q;
        for (int i = 0; i < STEPS; i++) begin
            walk = (walk >> 1) ^ (walk[0] ? FB_MASK : '0);
        end
        state_d = adv_i ? walk : state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= (seed_i == '0) ? ZERO_SEED : seed_i;
        else        state_q <= state_d;
    end

    assign state_o = state_q[OUT_W-1:0];
endmodule

// File: rtl/ltg_level_sel.sv
module ltg_level_sel
    import ltg_pkg::*;
#(
    parameter int unsigned LEVELS = 5,
    parameter int unsigned LVL_W  = 3
) (
    input  logic [DRAW_W*(LEVELS-1)-1:0] draw_i,
    input  logic [DRAW_W-1:0]            alpha_i,
    output logic [LVL_W-1:0]             level_o
);
    logic [LEVELS-2:0] escape;

    for (genvar k = 0; k < LEVELS - 1; k++) begin : g_cmp
        assign escape[k] = draw_i[DRAW_W*k +: DRAW_W] < alpha_i;
    end

    always_comb begin
        level_o = LVL_W'(LEVELS);
        for (int k = LEVELS - 2; k >= 0; k--) begin
            if (!escape[k]) level_o = LVL_W'(k + 1);
        end
    end
endmodule

// File: rtl/ltg_dest_build.sv
module ltg_dest_build
    import ltg_pkg::*;
#(
    parameter int unsigned LEVELS = 5,
    parameter int unsigned LVL_W  = 3,
    localparam int unsigned ADDR_W = DIGIT_W * LEVELS
) (
    input  logic [ADDR_W-1:0]         src_i,
    input  logic [LVL_W-1:0]          level_i,
    input  logic [DRAW_W-1:0]         off_i,
    input  logic [ADDR_W-DIGIT_W-1:0] fill_i,
    output logic [ADDR_W-1:0]         dst_o
);
    logic [DRAW_W-1:0]  off_mod;
    logic [DIGIT_W-1:0] shift;

    assign off_mod = off_i % DRAW_W'(3);
    assign shift   = DIGIT_W'(1) + off_mod[DIGIT_W-1:0];

    for (genvar d = 0; d < LEVELS; d++) begin : g_digit
        localparam logic [LVL_W-1:0] HERE = LVL_W'(d + 1);
        logic [DIGIT_W-1:0] own;
        assign own = src_i[DIGIT_W*d +: DIGIT_W];
        if (d == LEVELS - 1) begin : g_top
            assign dst_o[DIGIT_W*d +: DIGIT_W] =
                (level_i == HERE) ? own + shift : own;
        end else begin : g_low
            assign dst_o[DIGIT_W*d +: DIGIT_W] =
                (level_i <  HERE) ? own :
                (level_i == HERE) ? own + shift :
                                    fill_i[DIGIT_W*d +: DIGIT_W];
        end
    end
endmodule

// File: rtl/loc_traffic_gen.sv
module loc_traffic_gen
    import ltg_pkg::*;
#(
    parameter int unsigned LEVELS = 5,
    parameter int unsigned FLIT_W = 256,
    parameter int unsigned RATE_W = 16,
    parameter int unsigned SEQ_W  = 16,
    localparam int unsigned ADDR_W  = DIGIT_W * LEVELS,
    localparam int unsigned LVL_W   = $clog2(LEVELS + 1),
    localparam int unsigned OFF_LSB = DRAW_W * (LEVELS - 1),
    localparam int unsigned RND_LSB = OFF_LSB + DRAW_W,
    localparam int unsigned USE_W   = RND_LSB + ADDR_W - DIGIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] seed_i,
    input  logic               enable_i,
    input  logic [ADDR_W-1:0]  src_id_i,
    input  logic [DRAW_W-1:0]  alpha_i,
    input  logic [RATE_W-1:0]  rate_i,
    output logic               flit_valid_o,
    input  logic               flit_ready_i,
    output logic [FLIT_W-1:0]  flit_data_o
);
    typedef struct packed {
        logic              valid;
        logic [RATE_W-1:0] gap;
        logic [SEQ_W-1:0]  cnt;
        logic [SEQ_W-1:0]  seq;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } gen_state_t;

    gen_state_t st_q, st_d;
    logic               adv;
    logic [USE_W-1:0]   rnd;
    logic [LVL_W-1:0]   level;
    logic [ADDR_W-1:0]  dst_w;

    ltg_lfsr #(.STEPS(STATE_W), .OUT_W(USE_W)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_i  (seed_i),
        .adv_i   (adv),
        .state_o (rnd)
    );

    ltg_level_sel #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_level (
        .draw_i  (rnd[OFF_LSB-1:0]),
        .alpha_i (alpha_i),
        .level_o (level)
    );

    ltg_dest_build #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_dest (
        .src_i   (src_id_i),
        .level_i (level),
        .off_i   (rnd[OFF_LSB +: DRAW_W]),
        .fill_i  (rnd[RND_LSB +: ADDR_W-DIGIT_W]),
        .dst_o   (dst_w)
    );

    always_comb begin
        st_d = st_q;
        adv  = 1'b0;
        if (st_q.valid) begin
            if (flit_ready_i) begin
                st_d.valid = 1'b0;
                st_d.gap   = rate_i;
            end
        end else if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - RATE_W'(1);
        end else if (enable_i) begin
            st_d.valid = 1'b1;
            st_d.src   = src_id_i;
            st_d.dst   = dst_w;
            st_d.seq   = st_q.cnt;
            st_d.cnt   = st_q.cnt + SEQ_W'(1);
            adv        = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flit_valid_o = st_q.valid;
    assign flit_data_o  = {{(FLIT_W - SEQ_W - 2*ADDR_W){1'b0}}, st_q.seq, st_q.dst, st_q.src};
endmodule

// File: rtl/ltg_chk.sv
module ltg_chk #(
    parameter int unsigned FLIT_W = 256,
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic [7:0]        alpha_i,
    input logic              flit_valid_o,
    input logic              flit_ready_i,
    input logic [FLIT_W-1:0] flit_data_o
);
    logic [ADDR_W-1:0] f_src, f_dst;
    assign f_src = flit_data_o[ADDR_W-1:0];
    assign f_dst = flit_data_o[2*ADDR_W-1:ADDR_W];

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid_o && !flit_ready_i |=> flit_valid_o && $stable(flit_data_o));

    a_r8_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid_o && flit_ready_i |=> !flit_valid_o);

    a_r5_dst_not_src: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid_o |-> f_dst != f_src);

    a_r4_alpha_zero_local: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flit_valid_o) && $past(alpha_i) == 8'd0 |->
            f_dst[ADDR_W-1:2] == f_src[ADDR_W-1:2]);

    a_r9_no_start_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !flit_valid_o && !enable_i |=> !flit_valid_o);
endmodule

bind loc_traffic_gen ltg_chk #(.FLIT_W(FLIT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .alpha_i      (alpha_i),
    .flit_valid_o (flit_valid_o),
    .flit_ready_i (flit_ready_i),
    .flit_data_o  (flit_data_o)
);

// File: tb/loc_traffic_gen_bench.sv
module loc_traffic_gen_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  seed = '0;
    logic         enable = 1'b0;
    logic [9:0]   src_id = '0;
    logic [7:0]   alpha = '0;
    logic [15:0]  rate = '0;
    logic         ready = 1'b0;
    logic         valid;
    logic [255:0] data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] model;
    logic [15:0] exp_seq;
    int          lvl5_hits;
    int          local_bad;

    always #10 clk = ~clk;

    loc_traffic_gen u_loc_traffic_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .seed_i       (seed),
        .enable_i     (enable),
        .src_id_i     (src_id),
        .alpha_i      (alpha),
        .rate_i       (rate),
        .flit_valid_o (valid),
        .flit_ready_i (ready),
        .flit_data_o  (data)
    );

    task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] step64(logic [63:0] s);
        logic [63:0] v;
        v = s;
        for (int i = 0; i < 64; i++) v = v[0] ? ((v >> 1) ^ 64'hD800_0000_0000_0000) : (v >> 1);
        return v;
    endfunction

    function automatic int pick_level(logic [63:0] s, logic [7:0] a);
        int l;
        l = 5;
        for (int k = 3; k >= 0; k--) if (s[8*k +: 8] >= a) l = k + 1;
        return l;
    endfunction

    function automatic logic [9:0] exp_dst(logic [9:0] src, logic [63:0] s, logic [7:0] a);
        logic [9:0] d;
        logic [7:0] m;
        int l;
        l = pick_level(s, a);
        m = s[39:32] % 8'd3;
        for (int g = 0; g < 5; g++) begin
            if (g > l - 1)       d[2*g +: 2] = src[2*g +: 2];
            else if (g == l - 1) d[2*g +: 2] = src[2*g +: 2] + 2'd1 + m[1:0];
            else                 d[2*g +: 2] = s[40 + 2*g +: 2];
        end
        return d;
    endfunction

    task automatic do_reset(logic [63:0] sd);
        @(negedge clk);
        enable = 1'b0;
        ready  = 1'b0;
        seed   = sd;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model   = (sd == '0) ? 64'h1 : sd;
        exp_seq = '0;
        @(negedge clk);
        check(valid == 1'b0, "R1 idle after reset", {255'd0, valid}, 256'd0);
    endtask

    task automatic run_flits(int n, int rdy_pct);
        int   got;
        int   low_cnt;
        bit   prev_v;
        bit   prev_r;
        bit   r;
        logic [255:0] prev_d;
        logic [255:0] exp;
        got = 0; low_cnt = -1; prev_v = 0; prev_r = 0; prev_d = '0;
        enable = 1'b1;
        while (got < n) begin
            @(negedge clk);
            if (prev_v && !prev_r)
                check(valid && data == prev_d, "R7 stalled flit held", data, prev_d);
            if (low_cnt >= 0) begin
                if (!valid) low_cnt++;
                else begin
                    check(low_cnt == int'(rate) + 1, "R8 idle gap", 256'(low_cnt), 256'(int'(rate) + 1));
                    low_cnt = -1;
                end
            end
            r = ($urandom_range(99) < rdy_pct);
            ready = r;
            if (valid && r) begin
                exp = {220'd0, exp_seq, exp_dst(src_id, model, alpha), src_id};
                check(data[9:0] == src_id && data[255:36] == '0, "R2 source and padding", data, exp);
                check(data[35:20] == exp_seq, "R3 sequence", 256'(data[35:20]), 256'(exp_seq));
                check(data[19:10] == exp[19:10], "R5 R6 destination", 256'(data[19:10]), 256'(exp[19:10]));
                if (pick_level(model, alpha) == 5) lvl5_hits++;
                if (alpha == 8'd0 && data[19:12] != src_id[9:2]) local_bad++;
                model   = step64(model);
                exp_seq = exp_seq + 16'd1;
                got++;
                low_cnt = 0;
            end
            prev_v = valid; prev_r = r; prev_d = data;
        end
    endtask

    task automatic pause_check(int cycles);
        @(negedge clk);
        enable = 1'b0;
        ready  = 1'b1;
        repeat (cycles) begin
            @(negedge clk);
            if (valid) begin
                check(1'b0, "R9 no flit while disabled", {255'd0, valid}, 256'd0);
            end
        end
        checks++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        lvl5_hits = 0;
        local_bad = 0;

        // R1 zero seed replaced, R4 fully local traffic with alpha 0
        src_id = 10'h2A5; alpha = 8'd0; rate = 16'd0;
        do_reset(64'd0);
        run_flits(40, 100);
        check(local_bad == 0, "R4 alpha zero keeps level 1", 256'(local_bad), 256'd0);

        // random seed, mid threshold, backpressure
        src_id = 10'($urandom); alpha = 8'd128; rate = 16'd3;
        do_reset({$urandom, $urandom});
        run_flits(60, 50);

        // R4 outermost level reached with alpha 255
        lvl5_hits = 0;
        src_id = 10'($urandom); alpha = 8'd255; rate = 16'd0;
        do_reset(64'hCAFE_F00D_1234_5678);
        run_flits(60, 70);
        check(lvl5_hits > 0, "R4 level 5 reached", 256'(lvl5_hits), 256'd1);

        // R9 pause between bursts, state must not advance
        src_id = 10'h000; alpha = 8'd40; rate = 16'd7;
        do_reset({$urandom, $urandom});
        run_flits(20, 80);
        pause_check(25);
        run_flits(20, 60);

        // all-ones source, random threshold
        src_id = 10'h3FF; alpha = 8'($urandom); rate = 16'd1;
        do_reset({$urandom, $urandom});
        run_flits(50, 40);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule